// File: doc/BRIEF.md
# Banked Interrupt Aggregator with Per-Source Trigger Control

This block collects peripheral interrupt lines in groups of 32, called banks, and repeats that group a parameterised number of times. Each source can be programmed as edge or level triggered, and as active high (rising) or active low (falling). Every source keeps its own pending bit. Each bank drives one request line toward the processor and also gives the index of its lowest-numbered enabled pending source.

Software reaches the block through a simple register bus. A write takes effect at the clock edge that samples it. Read data is registered and appears one cycle after the read strobe. Each bank has six registers in a 24-byte window:

- a read-only pending view,
- an enable mask,
- a write-one-to-set register,
- a write-one-to-clear register,
- a polarity mask,
- a trigger-mode mask.

Source inputs pass through a two-stage synchroniser before detection.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Bank b occupies byte addresses b*0x18 to b*0x18+0x17. Offsets within the window are: 0x00 pending (read only), 0x04 enable, 0x08 set (write only), 0x0C clear (write only), 0x10 polarity, 0x14 trigger mode. The set and clear offsets read as 0. Global source s is bit (s & 31) of bank (s >> 5). Read data appears on the cycle after the read strobe.
- R2: After reset, all pending bits are 0, all enables are 0 and all polarity bits are 1. Trigger mode is 0 everywhere except bits 13, 14 and 15 of bank 0, which reset to 1.
- R3: A source with trigger-mode bit 1 and polarity 1 latches its pending bit on a rising input edge. The bit stays set after the input returns low.
- R4: A source with trigger-mode bit 1 and polarity 0 latches on a falling edge and ignores rising edges.
- R5: A source with trigger-mode bit 0 has a pending bit that follows its input: the input itself when polarity is 1, the inverted input when polarity is 0. A clear write has no lasting effect while the input stays active.
- R6: Writing 1s to the clear register drops the matching pending bits. Bits written as 0 are left unchanged.
- R7: Writing 1s to the set register forces the matching pending bits to 1, for either trigger mode. They stay set until cleared, even with the input inactive.
- R8: If an edge is detected in the same cycle that a clear write hits the same bit, the bit stays set.
- R9: The bank request output is 1 exactly when some pending bit of that bank has its enable bit set. It updates at the same clock edge as the pending and enable registers.
- R10: When the request is active, the bank index output gives the lowest bit position that is both pending and enabled, and the valid flag is 1. Otherwise the valid flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | SRC_PER_BANK | Write data |
| bus_rdata | output | SRC_PER_BANK | Registered read data |
| src_in | input | NUM_BANKS*SRC_PER_BANK | Asynchronous interrupt sources, bank-major |
| irq_o | output | NUM_BANKS | Per-bank request line |
| irq_idx | output | NUM_BANKS*IDX_W | Per-bank lowest pending enabled index |
| irq_idx_vld | output | NUM_BANKS | Per-bank index valid |

## Verification
Two events can meet on one pending bit in a single cycle: the capture of a synchronised edge, and a software clear write. The bench raises a source input and then times the clear write so it lands on exactly the edge where the detector fires. That edge is two clock edges after the input is sampled. A read of the pending register and the request line must then still show the bit set. A second clear, issued after that cycle, must drop it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [2:0] {
    RS_PEND  = 3'd0,
    RS_MASK  = 3'd1,
    RS_FORCE = 3'd2,
    RS_ACK   = 3'd3,
    RS_POL   = 3'd4,
    RS_TRIG  = 3'd5,
    RS_NONE  = 3'd7
  } reg_sel_e;

  localparam int BANK_STRIDE = 24;

  function automatic reg_sel_e decode_off(input int off);
    case (off)
      0:       return RS_PEND;
      4:       return RS_MASK;
      8:       return RS_FORCE;
      12:      return RS_ACK;
      16:      return RS_POL;
      20:      return RS_TRIG;
      default: return RS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irqc_lowest.sv
module irqc_lowest #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             vld
);
  always_comb begin
    idx = '0;
    vld = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IDX_W'(i);
        vld = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int          W         = 32,
  parameter int          IDX_W     = $clog2(W),
  parameter logic [W-1:0] TRIG_INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     src_sync,
  input  logic [W-1:0]     wdata,
  input  logic             we_mask,
  input  logic             we_pol,
  input  logic             we_trig,
  input  logic [W-1:0]     force_bits,
  input  logic [W-1:0]     ack_bits,
  output logic [W-1:0]     pend_q,
  output logic [W-1:0]     mask_q,
  output logic [W-1:0]     pol_q,
  output logic [W-1:0]     trig_q,
  output logic             req_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             idx_vld_q
);
  logic [W-1:0] act, act_q, det, soft_q, soft_n;
  logic [W-1:0] edge_n, pend_n, mask_n, live;
  logic [IDX_W-1:0] idx_n;
  logic             vld_n;

  assign act    = src_sync ~^ pol_q;
  assign det    = act & ~act_q & trig_q;
  assign soft_n = ~trig_q & ((soft_q & ~ack_bits) | force_bits);
  assign edge_n = (pend_q & ~ack_bits) | det | force_bits;
  assign pend_n = (trig_q & edge_n) | (~trig_q & (act | soft_n));
  assign mask_n = we_mask ? wdata : mask_q;
  assign live   = pend_n & mask_n;

  irqc_lowest #(.W(W), .IDX_W(IDX_W)) u_low (
    .vec (live),
    .idx (idx_n),
    .vld (vld_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= '0;
      soft_q    <= '0;
      pend_q    <= '0;
      mask_q    <= '0;
      pol_q     <= '1;
      trig_q    <= TRIG_INIT;
      req_q     <= 1'b0;
      idx_q     <= '0;
      idx_vld_q <= 1'b0;
    end else begin
      act_q     <= act;
      soft_q    <= soft_n;
      pend_q    <= pend_n;
      mask_q    <= mask_n;
      if (we_pol)  pol_q  <= wdata;
      if (we_trig) trig_q <= wdata;
      req_q     <= |live;
      idx_q     <= idx_n;
      idx_vld_q <= vld_n;
    end
  end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
  parameter int          NUM_BANKS    = 2,
  parameter int          SRC_PER_BANK = 32,
  parameter int          ADDR_W       = 8,
  parameter int          SYNC_STAGES  = 2,
  parameter int          IDX_W        = $clog2(SRC_PER_BANK),
  parameter logic [SRC_PER_BANK-1:0] B0_TRIG_INIT = 32'h0000_E000
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bus_wr,
  input  logic                              bus_rd,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [SRC_PER_BANK-1:0]           bus_wdata,
  output logic [SRC_PER_BANK-1:0]           bus_rdata,
  input  logic [NUM_BANKS*SRC_PER_BANK-1:0] src_in,
  output logic [NUM_BANKS-1:0]              irq_o,
  output logic [NUM_BANKS*IDX_W-1:0]        irq_idx,
  output logic [NUM_BANKS-1:0]              irq_idx_vld
);
  import irqc_pkg::*;

  localparam int W = SRC_PER_BANK;

  logic [NUM_BANKS*W-1:0]         src_s;
  logic [NUM_BANKS-1:0][W-1:0]    st_w, en_w, pl_w, eg_w, set_w, clr_w, rdv;
  logic [W-1:0]                   rd_mux;

  irqc_sync #(.W(NUM_BANKS*W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (src_in),
    .q   (src_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BASE = b * BANK_STRIDE;
    localparam logic [W-1:0] TINIT = (b == 0) ? B0_TRIG_INIT : '0;
    logic     hit;
    reg_sel_e sel;

    assign hit = (int'(bus_addr) >= BASE) && (int'(bus_addr) < BASE + BANK_STRIDE);
    assign sel = hit ? decode_off(int'(bus_addr) - BASE) : RS_NONE;

    assign set_w[b] = (bus_wr && sel == RS_FORCE) ? bus_wdata : '0;
    assign clr_w[b] = (bus_wr && sel == RS_ACK)   ? bus_wdata : '0;

    always_comb begin
      case (sel)
        RS_PEND: rdv[b] = st_w[b];
        RS_MASK: rdv[b] = en_w[b];
        RS_POL:  rdv[b] = pl_w[b];
        RS_TRIG: rdv[b] = eg_w[b];
        default: rdv[b] = '0;
      endcase
    end

    irqc_bank #(.W(W), .IDX_W(IDX_W), .TRIG_INIT(TINIT)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .src_sync   (src_s[b*W +: W]),
      .wdata      (bus_wdata),
      .we_mask    (bus_wr && sel == RS_MASK),
      .we_pol     (bus_wr && sel == RS_POL),
      .we_trig    (bus_wr && sel == RS_TRIG),
      .force_bits (set_w[b]),
      .ack_bits   (clr_w[b]),
      .pend_q     (st_w[b]),
      .mask_q     (en_w[b]),
      .pol_q      (pl_w[b]),
      .trig_q     (eg_w[b]),
      .req_q      (irq_o[b]),
      .idx_q      (irq_idx[b*IDX_W +: IDX_W]),
      .idx_vld_q  (irq_idx_vld[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) rd_mux = rd_mux | rdv[b];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk #(
  parameter int NUM_BANKS    = 2,
  parameter int SRC_PER_BANK = 32,
  parameter int IDX_W        = 5
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic [NUM_BANKS-1:0]                 irq_o,
  input logic [NUM_BANKS*IDX_W-1:0]           irq_idx,
  input logic [NUM_BANKS-1:0]                 irq_idx_vld,
  input logic [NUM_BANKS-1:0][SRC_PER_BANK-1:0] st_w,
  input logic [NUM_BANKS-1:0][SRC_PER_BANK-1:0] en_w,
  input logic [NUM_BANKS-1:0][SRC_PER_BANK-1:0] eg_w,
  input logic [NUM_BANKS-1:0][SRC_PER_BANK-1:0] set_w,
  input logic [NUM_BANKS-1:0][SRC_PER_BANK-1:0] clr_w
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    logic [SRC_PER_BANK-1:0] pend, hold, below;
    logic [IDX_W-1:0]        ix;

    assign pend  = st_w[b] & en_w[b];
    assign hold  = eg_w[b] & st_w[b] & ~clr_w[b];
    assign ix    = irq_idx[b*IDX_W +: IDX_W];
    assign below = (SRC_PER_BANK'(1) << ix) - SRC_PER_BANK'(1);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (st_w[b] == '0 && en_w[b] == '0)); // R2

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((st_w[b] & eg_w[b] & $past(hold)) == (eg_w[b] & $past(hold)))); // R3

    AST_FORCE_STICK: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((st_w[b] & $past(set_w[b])) == $past(set_w[b]))); // R7

    AST_REQ_MATCH: assert property (@(posedge clk) disable iff (rst)
      irq_o[b] == (|pend)); // R9

    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (rst)
      irq_idx_vld[b] |-> (pend[ix] && ((pend & below) == '0))); // R10

    AST_VLD_REQ: assert property (@(posedge clk) disable iff (rst)
      irq_idx_vld[b] == irq_o[b]); // R10
  end
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .SRC_PER_BANK(SRC_PER_BANK), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .irq_idx(irq_idx), .irq_idx_vld(irq_idx_vld),
  .st_w(st_w), .en_w(en_w), .eg_w(eg_w), .set_w(set_w), .clr_w(clr_w)
);

// File: tb/irq_bank_ctrl_tb.sv
module irq_bank_ctrl_tb;
  localparam int NB = 2;
  localparam int W  = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [NB*W-1:0] src_in = '0;
  logic [NB-1:0] irq_o, irq_idx_vld;
  logic [NB*5-1:0] irq_idx;

  int n_run = 0, n_fail = 0;
  logic rd_seen = 1'b0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic         done = 1'b0;

  always #4 clk = ~clk;

  irq_bank_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_o(irq_o), .irq_idx(irq_idx), .irq_idx_vld(irq_idx_vld)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  initial begin
    forever begin
      @(negedge clk);
      if (rd_seen) begin
        if (exp_q.size() == 0) check(bus_rdata, 32'hx, "scoreboard underflow");
        else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R2 reset values
    check({31'd0, irq_o[0] | irq_o[1]}, 32'd0, "R2 request low after reset");
    rd(8'h10, 32'hFFFF_FFFF, "R2 bank0 polarity");
    rd(8'h14, 32'h0000_E000, "R2 bank0 trigger");
    rd(8'h2C, 32'h0, "R2 bank1 trigger");
    rd(8'h28, 32'hFFFF_FFFF, "R2 bank1 polarity");
    rd(8'h00, 32'h0, "R2 bank0 pending");
    rd(8'h04, 32'h0, "R2 bank0 enable");
    // R1 register window of bank 1
    wr(8'h1C, 32'hA5A5_0000);
    rd(8'h1C, 32'hA5A5_0000, "R1 bank1 enable readback");
    wr(8'h28, 32'hFFFF_FF7F);
    idle(4);
    rd(8'h28, 32'hFFFF_FF7F, "R1 bank1 polarity readback");
    rd(8'h20, 32'h0, "R1 set reads zero");
    rd(8'h24, 32'h0, "R1 clear reads zero");
    // R5 active-low level on source 39 (bank1 bit7)
    rd(8'h18, 32'h0000_0080, "R5 active-low level pending");
    check({31'd0, irq_o[1]}, 32'd0, "R9 disabled pending gives no request");
    src_in[39] = 1'b1;
    idle(4);
    rd(8'h18, 32'h0, "R5 active-low released");
    // R5 active-high level on bank0 bit3
    wr(8'h04, 32'h8);
    src_in[3] = 1'b1;
    idle(4);
    rd(8'h00, 32'h8, "R5 level high pending");
    check({31'd0, irq_o[0]}, 32'd1, "R9 request on enabled pending");
    check({26'd0, irq_idx_vld[0], irq_idx[4:0]}, 32'h23, "R10 index 3");
    wr(8'h0C, 32'h8);
    idle(2);
    rd(8'h00, 32'h8, "R5 clear no effect while active");
    src_in[3] = 1'b0;
    idle(4);
    rd(8'h00, 32'h0, "R5 level follows input low");
    check({31'd0, irq_o[0]}, 32'd0, "R9 request drops");
    // R3 rising edge on bit14
    src_in[14] = 1'b1;
    idle(4);
    src_in[14] = 1'b0;
    idle(4);
    rd(8'h00, 32'h4000, "R3 edge latched after input low");
    check({31'd0, irq_o[0]}, 32'd0, "R9 latched but disabled");
    wr(8'h04, 32'h4000);
    check({26'd0, irq_idx_vld[0], irq_idx[4:0]}, 32'h2E, "R10 index 14");
    check({31'd0, irq_o[0]}, 32'd1, "R9 request with enable");
    // R6 clear
    wr(8'h0C, 32'hFFFF_BFFF);
    rd(8'h00, 32'h4000, "R6 zero bits ignored");
    wr(8'h0C, 32'h4000);
    rd(8'h00, 32'h0, "R6 one bit clears");
    check({31'd0, irq_o[0]}, 32'd0, "R9 request after clear");
    // R4 falling edge on bit13
    wr(8'h10, 32'hFFFF_DFFF);
    idle(4);
    wr(8'h0C, 32'h2000);
    rd(8'h00, 32'h0, "R4 pending clean after polarity change");
    src_in[13] = 1'b1;
    idle(4);
    rd(8'h00, 32'h0, "R4 rising ignored");
    src_in[13] = 1'b0;
    idle(4);
    rd(8'h00, 32'h2000, "R4 falling latched");
    wr(8'h0C, 32'h2000);
    rd(8'h00, 32'h0, "R4 cleared");
    // R7 software set
    wr(8'h08, 32'h0010_0000);
    idle(4);
    rd(8'h00, 32'h0010_0000, "R7 set on level source holds");
    wr(8'h08, 32'h0000_8000);
    rd(8'h00, 32'h0010_8000, "R7 set on edge source");
    wr(8'h0C, 32'h0010_8000);
    rd(8'h00, 32'h0, "R7 cleared after set");
    // R10 lowest index ordering
    wr(8'h08, 32'h0010_0200);
    wr(8'h04, 32'h0010_0200);
    check({26'd0, irq_idx_vld[0], irq_idx[4:0]}, 32'h29, "R10 lowest is 9");
    wr(8'h0C, 32'h200);
    check({26'd0, irq_idx_vld[0], irq_idx[4:0]}, 32'h34, "R10 next is 20");
    wr(8'h0C, 32'h0010_0000);
    check({30'd0, irq_idx_vld[0], irq_o[0]}, 32'd0, "R10 none pending");
    // R8 edge capture meets clear in the same cycle
    wr(8'h04, 32'h8000);
    src_in[15] = 1'b1;
    @(negedge clk);
    wr(8'h0C, 32'h8000);
    rd(8'h00, 32'h8000, "R8 edge wins over clear");
    check({31'd0, irq_o[0]}, 32'd1, "R8 request kept");
    src_in[15] = 1'b0;
    wr(8'h0C, 32'h8000);
    idle(3);
    rd(8'h00, 32'h0, "R8 later clear drops bit");
    idle(3);
    check(exp_q.size(), 32'd0, "scoreboard drained");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule